// File: doc/BRIEF.md
# Two-Channel DAC Code Register Core

This block is the digital state of a two-channel voltage-output converter. A serial front end hands it complete commands, each an opcode, a per-channel select mask and a 12-bit data word, qualified by a one-cycle valid strobe. Every channel holds two registers in series. The staging register takes a new setting without disturbing the output. The live register drives the converter. Commands write the staging register, copy staging to live, or write both at once. Other commands clear the codes, power channels up and down, or choose the reference source.

Power-down changes only the per-channel indicator. Both code registers keep their contents and still accept updates while the channel is off. Two inputs clear the codes. The power-on reset returns all state to its defaults. The asynchronous active-low clear empties both register stages of both channels at once. It also discards commands until its release has passed a two-flop synchronizer.

Top module: `dacreg_core`

## Requirements
- R1: After power-on reset, both live codes are zero, both power-down flags are 0, the reference mode is 0 (external) and the error strobe is low.
- R2: Opcode 0x0 loads the data word into the staging register of each channel whose mask bit is set. The live code does not change.
- R3: Opcode 0x1 copies the staging register into the live register of each selected channel.
- R4: Opcode 0x2 writes the data word into both the staging and the live register of each selected channel.
- R5: Mask bit i selects channel i. Any combination of mask bits is allowed, and channels whose bit is clear are left unchanged.
- R6: Opcode 0x4 sets the power-down flag of each selected channel to data bit 0. Power-down leaves both code registers intact, and they accept writes and loads while down.
- R7: Opcode 0x5 zeroes every staging and live register regardless of mask. The power-down flags and the reference mode are kept.
- R8: Opcode 0x6 zeroes every code register, clears all power-down flags and sets the reference mode back to 0.
- R9: Opcode 0x7 sets the reference mode to data bits [1:0]: 0 external, 1 internal 2.048 V, 2 internal 2.500 V, 3 internal 4.096 V.
- R10: Any opcode other than 0x0, 0x1, 0x2, 0x4, 0x5, 0x6 or 0x7 changes no state. It pulses the error output high for exactly the cycle after the edge that accepted it.
- R11: While the clear input is low, all staging and live registers are zero at once, without waiting for a clock edge, and commands are ignored. The first command accepted is one sampled on the third rising edge after the clear input rises.
- R12: Each accepted command takes effect on the rising edge that samples its valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low code clear |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode |
| cmd_mask | input | 2 | Channel select, bit i for channel i |
| cmd_data | input | 12 | Command data word |
| dac_code | output | 24 | Live codes, channel i in bits [12i+11:12i] |
| pwr_down | output | 2 | Power-down flag per channel |
| ref_mode | output | 2 | Reference selection |
| cmd_err | output | 1 | One-cycle strobe for an unknown opcode |

## Verification
A wrong live register appears on dac_code on the cycle after the faulty command. A wrong staging register stays hidden until a load copies it out, so the bench follows writes with loads to bring staging faults to the ports. Errors in power-down, reference mode and the error strobe appear on the outputs one edge after the command that caused them. A fault in the clear synchronizer shows only as a command accepted or dropped around the release edges, so commands are issued on each of those edges.

// File: rtl/dacreg_core.sv
module dacreg_core #(
  parameter int DW  = 12,
  parameter int NCH = 2,
  parameter int OPW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             cmd_valid,
  input  logic [OPW-1:0]   cmd_op,
  input  logic [NCH-1:0]   cmd_mask,
  input  logic [DW-1:0]    cmd_data,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]   pwr_down,
  output logic [1:0]       ref_mode,
  output logic             cmd_err
);
  localparam logic [OPW-1:0] OP_WR   = OPW'(0);
  localparam logic [OPW-1:0] OP_LD   = OPW'(1);
  localparam logic [OPW-1:0] OP_WL   = OPW'(2);
  localparam logic [OPW-1:0] OP_PWR  = OPW'(4);
  localparam logic [OPW-1:0] OP_CLR  = OPW'(5);
  localparam logic [OPW-1:0] OP_RST  = OPW'(6);
  localparam logic [OPW-1:0] OP_REF  = OPW'(7);

  logic [1:0] clr_q;
  logic       accept, take, zap_n;
  logic       do_wr, do_ld, do_wl, do_pwr, do_clr, do_rst, do_ref, wipe, bad_op;

  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n)      clr_q <= 2'b11;
    else if (!clr_n) clr_q <= 2'b00;
    else             clr_q <= {clr_q[0], 1'b1};
  end

  assign accept = clr_q[1];
  assign take   = cmd_valid & accept;
  assign zap_n  = rst_n & clr_n;

  assign do_wr  = take && cmd_op == OP_WR;
  assign do_ld  = take && cmd_op == OP_LD;
  assign do_wl  = take && cmd_op == OP_WL;
  assign do_pwr = take && cmd_op == OP_PWR;
  assign do_clr = take && cmd_op == OP_CLR;
  assign do_rst = take && cmd_op == OP_RST;
  assign do_ref = take && cmd_op == OP_REF;
  assign wipe   = do_clr | do_rst;
  assign bad_op = take & ~(do_wr | do_ld | do_wl | do_pwr | do_clr | do_rst | do_ref);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] stage_r, live_r;
    logic          sel;
    assign sel = cmd_mask[ch];

    always_ff @(posedge clk or negedge zap_n) begin
      if (!zap_n) begin
        stage_r <= '0;
        live_r  <= '0;
      end else if (wipe) begin
        stage_r <= '0;
        live_r  <= '0;
      end else begin
        if ((do_wr | do_wl) & sel) stage_r <= cmd_data;
        if (do_wl & sel)           live_r  <= cmd_data;
        else if (do_ld & sel)      live_r  <= stage_r;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pwr_down[ch] <= 1'b0;
      else if (do_rst)         pwr_down[ch] <= 1'b0;
      else if (do_pwr & sel)   pwr_down[ch] <= cmd_data[0];
    end

    assign dac_code[ch*DW +: DW] = live_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_mode <= 2'd0;
      cmd_err  <= 1'b0;
    end else begin
      cmd_err <= bad_op;
      if (do_rst)      ref_mode <= 2'd0;
      else if (do_ref) ref_mode <= cmd_data[1:0];
    end
  end
endmodule

module dacreg_core_chk #(
  parameter int DW  = 12,
  parameter int NCH = 2,
  parameter int OPW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              cmd_valid,
  input logic [OPW-1:0]    cmd_op,
  input logic [NCH*DW-1:0] dac_code,
  input logic [NCH-1:0]    pwr_down,
  input logic [1:0]        ref_mode,
  input logic              cmd_err,
  input logic              accept
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  function automatic logic known(input logic [OPW-1:0] op);
    return op == OPW'(0) || op == OPW'(1) || op == OPW'(2) || op == OPW'(4) ||
           op == OPW'(5) || op == OPW'(6) || op == OPW'(7);
  endfunction

  p_clr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_code == '0);

  p_live_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(cmd_valid) && clr_n && $past(clr_n) |-> $stable(dac_code));

  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    seen && cmd_err |-> $past(cmd_valid) && !known($past(cmd_op)));

  p_pd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(cmd_valid) |-> $stable(pwr_down));

  p_ref_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !($past(cmd_valid) && ($past(cmd_op) == OPW'(7) || $past(cmd_op) == OPW'(6)))
    |-> $stable(ref_mode));

  p_wipe_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(cmd_valid && accept && cmd_op == OPW'(5)) |-> dac_code == '0);
endmodule

bind dacreg_core dacreg_core_chk #(.DW(DW), .NCH(NCH), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .dac_code(dac_code), .pwr_down(pwr_down), .ref_mode(ref_mode), .cmd_err(cmd_err),
  .accept(accept)
);

// File: tb/dacreg_core_test.sv
module dacreg_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0, clr_n = 1'b1, cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [1:0]  cmd_mask = '0;
  logic [11:0] cmd_data = '0;
  logic [23:0] dac_code;
  logic [1:0]  pwr_down, ref_mode;
  logic        cmd_err;

  dacreg_core uut (.*);

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0;
  string phase = "R1";
  int stage_m[2], live_m[2], pd_m[2], ref_m, err_m, rel;
  bit done = 0;

  function automatic bit op_known(int op);
    return op == 0 || op == 1 || op == 2 || op == 4 || op == 5 || op == 6 || op == 7;
  endfunction

  always @(negedge clr_n) begin
    for (int i = 0; i < 2; i++) begin stage_m[i] = 0; live_m[i] = 0; end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin stage_m[i] = 0; live_m[i] = 0; pd_m[i] = 0; end
      ref_m = 0; err_m = 0; rel = 2;
    end else begin
      bit acc;
      int op;
      acc = clr_n && rel >= 2 && cmd_valid;
      op = int'(cmd_op);
      err_m = acc && !op_known(op);
      if (!clr_n) rel = 0;
      else if (rel < 2) rel++;
      if (acc) begin
        if (op == 5 || op == 6)
          for (int i = 0; i < 2; i++) begin stage_m[i] = 0; live_m[i] = 0; end
        if (op == 6) begin pd_m[0] = 0; pd_m[1] = 0; ref_m = 0; end
        if (op == 7) ref_m = int'(cmd_data[1:0]);
        for (int i = 0; i < 2; i++) if (cmd_mask[i]) begin
          case (op)
            0: stage_m[i] = int'(cmd_data);
            1: live_m[i] = stage_m[i];
            2: begin stage_m[i] = int'(cmd_data); live_m[i] = int'(cmd_data); end
            4: pd_m[i] = int'(cmd_data[0]);
            default: ;
          endcase
        end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(phase, "ch0 code", int'(dac_code[11:0]), live_m[0]);
    check(phase, "ch1 code", int'(dac_code[23:12]), live_m[1]);
    check(phase, "pwr_down", int'(pwr_down), pd_m[1] * 2 + pd_m[0]);
    check(phase, "ref_mode", int'(ref_mode), ref_m);
    check(phase, "cmd_err", int'(cmd_err), err_m);
  end

  task automatic cmd(int op, int mask, int data);
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_mask = 2'(mask); cmd_data = 12'(data);
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    idle(3); #2; rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset code", int'(dac_code), 0);
    check("R1", "reset ref", int'(ref_mode), 0);
    phase = "R2"; cmd(0, 1, 12'h123); idle(1);
    check("R2", "live untouched", int'(dac_code[11:0]), 0);
    phase = "R3"; cmd(1, 1, 0); idle(1);
    @(negedge clk); check("R3", "load ch0", int'(dac_code[11:0]), 12'h123);
    phase = "R4"; cmd(2, 2, 12'hABC); idle(1);
    phase = "R5"; cmd(2, 3, 12'hFFF); cmd(0, 2, 12'h055); cmd(1, 3, 0);
    @(negedge clk); check("R5", "both loaded", int'(dac_code), 24'h055FFF);
    phase = "R6"; cmd(4, 1, 1); cmd(0, 1, 12'h7A0); cmd(1, 1, 0); cmd(4, 1, 0);
    @(negedge clk); check("R6", "kept through pd", int'(dac_code[11:0]), 12'h7A0);
    cmd(4, 3, 1);
    phase = "R9"; cmd(7, 0, 1); cmd(7, 0, 3); cmd(7, 0, 2);
    phase = "R7"; cmd(5, 0, 0);
    @(negedge clk); check("R7", "pd kept", int'(pwr_down), 3);
    check("R7", "ref kept", int'(ref_mode), 2);
    phase = "R10"; cmd(3, 3, 12'h111); cmd(8, 3, 12'h222); cmd(15, 3, 1);
    phase = "R12"; cmd(2, 3, 12'h801); cmd(2, 1, 12'h001); cmd(0, 3, 12'h0F0);
    phase = "R8"; cmd(6, 0, 0);
    @(negedge clk); check("R8", "pd cleared", int'(pwr_down), 0);
    phase = "R11";
    cmd(2, 3, 12'h3C3); cmd(7, 0, 1); cmd(0, 3, 12'h5A5);
    @(posedge clk); #2; clr_n = 1'b0; #1;
    check("R11", "async clear", int'(dac_code), 0);
    cmd(2, 3, 12'h999);
    @(posedge clk); #2; clr_n = 1'b1;
    cmd_valid = 1'b1; cmd_op = 4'd2; cmd_mask = 2'd3; cmd_data = 12'h444;
    idle(3); #2; cmd_data = 12'h666;
    @(posedge clk); #2; cmd_valid = 1'b0;
    cmd(1, 3, 0); idle(2);
    @(posedge clk); #2; clr_n = 1'b0; cmd_valid = 1'b1; cmd_op = 4'd1; cmd_mask = 2'd3;
    @(posedge clk); #2; clr_n = 1'b1; cmd_valid = 1'b0;
    idle(3);
    finish_run();
  end
endmodule